// File: doc/BRIEF.md
# Pipelined Second-Order Recursive Section

This block evaluates a fixed all-pole resonator, w[k] = 1.608·w[k-1] − 0.9875·w[k-2] + u[k], on a stream of signed 16-bit samples. It uses fixed-point arithmetic throughout. Each of the two coefficient multiplies has its own output register, and so does each of the two additions. The longest combinational path is therefore a single arithmetic operator between registers. The block can then be clocked close to the speed limit of one multiplier.

The feedback path passes through these registers. A new result must reach the state registers before the next sample can use it. The block therefore takes one sample at a time through a valid/ready handshake and refuses further input until the current result has been written back. Each result is presented on the output with a one-cycle valid pulse and held until the next one. The coefficients, word widths and rounding mode are parameters. Their defaults give the recursion above in Q2.14.

Top module: `iir2_section`

## Requirements
- R1: While the synchronous reset `rst` is high, `in_ready` and `out_valid` are 0. After reset, `out_sample` is 0 and both state values are 0, so the first result equals the first accepted input.
- R2: Each accepted sample u produces w = sat(round((26346·w1 − 16179·w2 + 16384·u) / 16384)). Here w1 and w2 are the two most recent results, all values are 16-bit two's complement, and the input enters with unity gain. When w is written back, w2 takes the old w1.
- R3: Rounding adds 8192 to the 2^-14 scaled sum and then shifts right arithmetically by 14, so exact halves go towards +infinity. Example: with w1 = 1, w2 = 0 and u = 0, the result is 2. Truncation would give 1.
- R4: A result above 32767 becomes 32767, and a result below −32768 becomes −32768. The state is stored clamped.
- R5: `out_valid` is a pulse exactly one cycle long. It appears in the cycle after the fourth rising edge, counting the edge that accepts the sample as the first. During that cycle `out_sample` carries the new result.
- R6: A sample is accepted on a rising edge where both `in_valid` and `in_ready` are 1. After that edge `in_ready` stays 0 for exactly 3 cycles. Any `in_valid` or `in_sample` activity during those cycles is ignored and has no effect on any result.
- R7: Between `out_valid` pulses, `out_sample` holds the most recent result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_sample | input | 16 | Signed input sample u[k] |
| out_valid | output | 1 | One-cycle pulse when a new result is written |
| out_sample | output | 16 | Most recent result w[k] |

## Verification
A behavioural model in the bench tracks the handshake timing, the pulse and the arithmetic cycle by cycle, and compares every output on every clock. The test drives `in_valid` continuously while the block is busy; a design that accepted early would read stale state and drift from the model. A unit value followed by a zero tells rounding apart from truncation (2 against 1). Long runs of full-scale positive and negative inputs push the resonator into both clamps; a design with a narrow accumulator or a missing clamp would wrap sign instead. An impulse response checks that the two state values shift in the right order.

// File: rtl/iir2_pkg.sv
package iir2_pkg;

   typedef enum logic {
      RND_TRUNC   = 1'b0,
      RND_NEAREST = 1'b1
   } rnd_mode_e;

   // Accumulator width: full product plus one bit per addition stage.
   function automatic int calc_acc_w(input int data_w, input int coef_w);
      return data_w + coef_w + 2;
   endfunction

endpackage

// File: rtl/iir2_mul_reg.sv
module iir2_mul_reg #(
   parameter int                       IN_W   = 16,
   parameter int                       COEF_W = 16,
   parameter logic signed [COEF_W-1:0] COEF   = '0
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           en,
   input  logic signed [IN_W-1:0]         din,
   output logic signed [IN_W+COEF_W-1:0]  prod_q
);
   localparam int PROD_W = IN_W + COEF_W;

   logic signed [PROD_W-1:0] din_ext;
   logic signed [PROD_W-1:0] coef_ext;
   logic signed [PROD_W-1:0] prod_d;

   assign din_ext  = {{COEF_W{din[IN_W-1]}}, din};
   assign coef_ext = {{IN_W{COEF[COEF_W-1]}}, COEF};
   assign prod_d   = din_ext * coef_ext;

   always_ff @(posedge clk) begin
      if (rst)     prod_q <= '0;
      else if (en) prod_q <= prod_d;
   end
endmodule

// File: rtl/iir2_add_reg.sv
module iir2_add_reg #(
   parameter int W = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                en,
   input  logic signed [W-1:0] a,
   input  logic signed [W-1:0] b,
   output logic signed [W-1:0] sum_q
);
   always_ff @(posedge clk) begin
      if (rst)     sum_q <= '0;
      else if (en) sum_q <= a + b;
   end
endmodule

// File: rtl/iir2_ctrl.sv
module iir2_ctrl #(
   parameter int STAGES = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              accept,
   output logic [STAGES-1:0] stage_v
);
   logic [STAGES-1:0] v_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("iir2_ctrl: STAGES must be at least 2");
      end
   endgenerate

   assign in_ready = ~rst & ~(|v_q);
   assign accept   = in_valid & in_ready;
   assign stage_v  = v_q;

   always_ff @(posedge clk) begin
      if (rst) v_q <= '0;
      else     v_q <= {v_q[STAGES-2:0], accept};
   end

   AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
      accept |=> !in_ready); // R6
   AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (rst)
      ($past(accept, 1) || $past(accept, 2) || $past(accept, 3)) |-> !in_ready); // R6
   AST_NO_STUCK_BUSY: assert property (@(posedge clk) disable iff (rst)
      !in_ready |-> ($past(accept, 1) || $past(accept, 2) || $past(accept, 3))); // R6
   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(v_q)); // R6
endmodule

// File: rtl/iir2_state.sv
module iir2_state #(
   parameter int DATA_W = 16,
   parameter int ACC_W  = 34,
   parameter int FRAC_W = 14
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wb_en,
   input  logic signed [ACC_W-1:0]  acc,
   output logic signed [DATA_W-1:0] w1_q,
   output logic signed [DATA_W-1:0] w2_q,
   output logic                     out_valid
);
   localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (DATA_W-1)) - 64'sd1);
   localparam logic signed [ACC_W-1:0] SAT_LO = -(ACC_W'(64'sd1 <<< (DATA_W-1)));

   logic signed [ACC_W-1:0]  shifted;
   logic signed [DATA_W-1:0] w_new;

   assign shifted = acc >>> FRAC_W;

   always_comb begin
      if (shifted > SAT_HI)      w_new = SAT_HI[DATA_W-1:0];
      else if (shifted < SAT_LO) w_new = SAT_LO[DATA_W-1:0];
      else                       w_new = shifted[DATA_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         w1_q      <= '0;
         w2_q      <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= wb_en;
         if (wb_en) begin
            w1_q <= w_new;
            w2_q <= w1_q;
         end
      end
   end

   AST_STATE_SHIFT: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (w2_q == $past(w1_q))); // R2
   AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> ($stable(w1_q) && $stable(w2_q))); // R7
   AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid); // R5
endmodule

// File: rtl/iir2_section.sv
module iir2_section #(
   parameter int                         DATA_W = 16,
   parameter int                         COEF_W = 16,
   parameter int                         FRAC_W = 14,
   parameter logic signed [COEF_W-1:0]   A1     = 26346,
   parameter logic signed [COEF_W-1:0]   A2     = -16179,
   parameter iir2_pkg::rnd_mode_e        RND    = iir2_pkg::RND_NEAREST
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_sample,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_sample
);
   localparam int PROD_W      = DATA_W + COEF_W;
   localparam int SUM1_W      = PROD_W + 1;
   localparam int ACC_W       = iir2_pkg::calc_acc_w(DATA_W, COEF_W);
   localparam int GUARD_W     = ACC_W - DATA_W - FRAC_W;
   localparam int PIPE_STAGES = 3;   // multiply, add products, add input
   localparam int NUM_TAPS    = 2;

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("iir2_section: DATA_W must be at least 2");
      end
      if (FRAC_W < 2 || FRAC_W >= COEF_W) begin : g_bad_frac
         $error("iir2_section: FRAC_W must lie in [2, COEF_W-1]");
      end
      if (GUARD_W < 1) begin : g_bad_guard
         $error("iir2_section: accumulator lacks guard bits");
      end
   endgenerate

   logic                     accept;
   logic [PIPE_STAGES-1:0]   stage_v;
   logic signed [DATA_W-1:0] w1, w2;
   logic signed [DATA_W-1:0] tap_in [NUM_TAPS];
   logic signed [PROD_W-1:0] tap_prod [NUM_TAPS];
   logic signed [DATA_W-1:0] u_s1, u_s2;
   logic signed [SUM1_W-1:0] sum1;
   logic signed [ACC_W-1:0]  sum1_ext, u_term, acc;
   logic [FRAC_W-1:0]        bias;

   iir2_ctrl #(.STAGES(PIPE_STAGES)) ctrl_i (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .accept   (accept),
      .stage_v  (stage_v)
   );

   assign tap_in[0] = w1;
   assign tap_in[1] = w2;

   // Stage 1: one registered multiplier per feedback tap.
   for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
      iir2_mul_reg #(
         .IN_W   (DATA_W),
         .COEF_W (COEF_W),
         .COEF   ((t == 0) ? A1 : A2)
      ) mul_i (
         .clk    (clk),
         .rst    (rst),
         .en     (accept),
         .din    (tap_in[t]),
         .prod_q (tap_prod[t])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         u_s1 <= '0;
         u_s2 <= '0;
      end else begin
         if (accept)     u_s1 <= in_sample;
         if (stage_v[0]) u_s2 <= u_s1;
      end
   end

   // Stage 2: sum of the two feedback products.
   iir2_add_reg #(.W(SUM1_W)) add_fb_i (
      .clk   (clk),
      .rst   (rst),
      .en    (stage_v[0]),
      .a     ({tap_prod[0][PROD_W-1], tap_prod[0]}),
      .b     ({tap_prod[1][PROD_W-1], tap_prod[1]}),
      .sum_q (sum1)
   );

   // Rounding bias sits in the vacant fraction bits of the input term.
   if (RND == iir2_pkg::RND_NEAREST) begin : g_rnd_nearest
      assign bias = {1'b1, {(FRAC_W-1){1'b0}}};
   end else begin : g_rnd_trunc
      assign bias = '0;
   end

   assign sum1_ext = {{(ACC_W-SUM1_W){sum1[SUM1_W-1]}}, sum1};
   assign u_term   = {{GUARD_W{u_s2[DATA_W-1]}}, u_s2, bias};

   // Stage 3: add the input sample at unity gain.
   iir2_add_reg #(.W(ACC_W)) add_in_i (
      .clk   (clk),
      .rst   (rst),
      .en    (stage_v[1]),
      .a     (sum1_ext),
      .b     (u_term),
      .sum_q (acc)
   );

   // Write-back: scale, clamp, shift state.
   iir2_state #(
      .DATA_W (DATA_W),
      .ACC_W  (ACC_W),
      .FRAC_W (FRAC_W)
   ) state_i (
      .clk       (clk),
      .rst       (rst),
      .wb_en     (stage_v[PIPE_STAGES-1]),
      .acc       (acc),
      .w1_q      (w1),
      .w2_q      (w2),
      .out_valid (out_valid)
   );

   assign out_sample = w1;

   AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(accept, 4)); // R5
   AST_ACCEPT_PRODUCES: assert property (@(posedge clk) disable iff (rst)
      $past(accept, 4) |-> out_valid); // R5
   AST_IDLE_OUTPUT: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_sample)); // R7
endmodule

// File: tb/iir2_section_tb_top.sv
module iir2_section_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_sample = '0;
   logic        out_valid;
   logic [15:0] out_sample;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model state
   int w1m = 0, w2m = 0, cnt = 0, pend = 0, exp_out = 0;
   bit exp_valid = 0;
   int unsigned seed = 32'h1234_5678;

   always #4 clk = ~clk;

   iir2_section dut_i (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_sample  (in_sample),
      .out_valid  (out_valid),
      .out_sample (out_sample)
   );

   function automatic int model_step(input int x1, input int x2, input int u);
      longint a;
      longint y;
      a = 64'sd26346 * x1 - 64'sd16179 * x2 + 64'sd16384 * u + 64'sd8192;
      y = a >>> 14;
      if (y > 32767)  y = 32767;
      if (y < -32768) y = -32768;
      return int'(y);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int got, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
      end
   endtask

   task automatic cycle(input bit v, input int s, input string tag);
      bit rdy_b;
      @(negedge clk);
      chk(in_ready === (cnt == 0), "R6", "in_ready", int'(in_ready), int'(cnt == 0));
      chk(out_valid === exp_valid, "R5", "out_valid", int'(out_valid), int'(exp_valid));
      chk($signed(out_sample) == exp_out, exp_valid ? tag : "R7", "out_sample",
          int'($signed(out_sample)), exp_out);
      in_valid  = v;
      in_sample = 16'(s);
      @(posedge clk);
      rdy_b     = (cnt == 0);
      exp_valid = 0;
      if (cnt > 0) begin
         cnt--;
         if (cnt == 0) begin
            w2m       = w1m;
            w1m       = pend;
            exp_out   = pend;
            exp_valid = 1;
         end
      end
      if (v && rdy_b) begin
         pend = model_step(w1m, w2m, 32'(signed'(16'(s))));
         cnt  = 3;
      end
   endtask

   task automatic send(input int s, input string tag);
      cycle(1'b1, s, tag);
      repeat (4) cycle(1'b0, 0, tag);
   endtask

   task automatic lit(input int expv, input string tag);
      #2;
      chk($signed(out_sample) == expv, tag, "out_sample literal",
          int'($signed(out_sample)), expv);
   endtask

   function automatic int next_rand();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return int'(seed >> 8);
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(in_ready === 1'b0, "R1", "in_ready in reset", int'(in_ready), 0);
      chk(out_valid === 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
      chk(out_sample === 16'd0, "R1", "out_sample in reset", int'(out_sample), 0);
      rst = 1'b0;

      // R1: first result from zero state equals input; R3: rounding case
      send(1, "R1");
      lit(1, "R1");
      send(0, "R3");
      lit(2, "R3");

      // R2: impulse response
      send(2000, "R2");
      repeat (15) send(0, "R2");

      // R6: in_valid held high with changing data while busy
      for (int i = 0; i < 40; i++) cycle(1'b1, (i * 97) % 1500 - 700, "R6");

      // R2/R6/R7: random valid pattern and data
      for (int i = 0; i < 400; i++) begin
         int r;
         r = next_rand();
         cycle(r[0] ^ r[3], (r >>> 4) % 2048, "R2");
      end
      repeat (4) cycle(1'b0, 0, "R2");

      // R4: positive and negative clamps
      repeat (6) send(32767, "R4");
      lit(32767, "R4");
      repeat (6) send(-32768, "R4");
      lit(-32768, "R4");
      repeat (8) send(0, "R4");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule